// File: doc/BRIEF.md
# Multi-channel periodic tick timer

This block generates periodic events for the rest of the chip. Two 8-bit down-counting prescalers divide the bus clock, and each one produces its own base tick. Four 16-bit channel counters each pick one of the two base ticks and count it down. When a channel's count runs out, the channel reloads, sets a sticky flag that can raise an interrupt request, and pulses a trigger line that other blocks can use to start their own work. The block has no pins that leave the chip.

Software sets the block up through a small word-wide register bus. A write takes effect on the clock edge at which `bus_wr` is high. A read is combinational from `bus_addr`. The bus has no handshake and never applies back-pressure, so every access completes in a single cycle. Three low-power mode inputs can stall the block. While stalled, every counter keeps its value and no events are generated.

Top module: `ptimer_top`

## Requirements
- R1: After reset, every register address reads 0, and `irq_o` and `trig_o` are low.
- R2: While the module is enabled, prescaler k decrements once per bus clock. At zero it reloads from its 8-bit load value L_k and emits a one-cycle base tick, so ticks repeat every L_k+1 clocks.
- R3: A channel with select bit 0 (address 2, bit n for channel n) counts base tick 0, and with the bit set it counts base tick 1. A tick that finds the count at zero is a time-out and reloads the channel from its load value C. Starting from a freshly enabled module, the channel's first trigger is seen (L+1)(C+1) clock edges after the enabling write.
- R4: Each time-out sets the channel's flag and drives `trig_o` high for the single cycle that follows the time-out.
- R5: A flag stays set until 1 is written to its bit at address 4. Writing 0 leaves it unchanged.
- R6: `irq_o[n]` is high exactly when flag n and interrupt enable n (address 3, bit n) are both set.
- R7: While the module enable (address 0 bit 0) or the channel enable (address 1 bit n) is clear, the channel count holds at its load value and no time-out occurs. The same applies to the prescalers when the module enable is clear.
- R8: While `stop_mode` is high, all counts hold and no flag or trigger is produced, whatever the control bits are.
- R9: While `wait_mode` is high, the block stalls if the wait-stall bit (address 0 bit 1) is set, and runs normally if it is clear.
- R10: While `freeze_mode` is high, the block stalls if the freeze-stall bit (address 0 bit 2) is set, and runs normally if it is clear.
- R11: Writing address 5 reloads the channels selected in bits 3:0 and the prescalers selected in bits 5:4 from their load values on that edge. This produces no time-out.
- R12: Register map. Address 0 holds the control bits and address 1 the channel enables. Address 2 holds the select bits and address 3 the interrupt enables. Address 4 holds the flags, and address 5 is the reload strobe, which reads 0. Addresses 6 and 7 hold the prescaler loads, 8 to 11 hold the channel loads, and 12 to 15 return the live channel counts. Every writable field reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| wait_mode | input | 1 | Wait low-power mode active |
| stop_mode | input | 1 | Stop low-power mode active |
| freeze_mode | input | 1 | Debug freeze mode active |
| irq_o | output | 4 | Per-channel interrupt requests |
| trig_o | output | 4 | Per-channel time-out trigger pulses |

## Verification
A write is visible on `bus_rdata` as soon as the edge that takes it has passed. `irq_o` follows the flag with no extra register. A time-out cycle shows up in the flag and on `trig_o` at the next edge, which puts the first trigger (L+1)(C+1) edges after the enabling write. The bench drives on the falling edge and samples one time unit after a rising edge or on a falling edge. It counts rising edges from the enabling or reloading write, so each latency is compared as an exact edge count. Stall checks set the mode pin half a cycle before an edge, so the count read right after that point must stay the same for the whole window.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int NCH = 4;
  localparam int NMT = 2;
  localparam int AW  = 4;
  localparam int DW  = 16;

  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_CHEN  = 4'd1;
  localparam logic [AW-1:0] A_SEL   = 4'd2;
  localparam logic [AW-1:0] A_IE    = 4'd3;
  localparam logic [AW-1:0] A_FLAG  = 4'd4;
  localparam logic [AW-1:0] A_RELD  = 4'd5;
  localparam logic [AW-1:0] A_MTLD0 = 4'd6;
  localparam logic [AW-1:0] A_CHLD0 = 4'd8;
  localparam logic [AW-1:0] A_CHCN0 = 4'd12;

  typedef struct packed {
    logic frz_stall;
    logic wait_stall;
    logic glob_en;
  } ctrl_t;
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stall,
  input  logic         force_ld,
  input  logic [W-1:0] load,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic         at_zero;

  assign at_zero = (cnt == '0);
  assign tick    = en & ~stall & ~force_ld & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (!en || force_ld)  cnt <= load;
    else if (!stall)           cnt <= at_zero ? load : cnt - W'(1);
  end

  // R2
  pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stall && !force_ld && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

  // R8
  pre_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stall && !force_ld) |=> $stable(cnt));
endmodule

// File: rtl/ptimer_channel.sv
module ptimer_channel #(
  parameter int W   = 16,
  parameter int NTB = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           stall,
  input  logic           force_ld,
  input  logic [NTB-1:0] ticks,
  input  logic           sel,
  input  logic [W-1:0]   load,
  output logic [W-1:0]   cnt,
  output logic           timeout,
  output logic           trig
);
  logic step;

  assign step    = en & ~stall & ~force_ld & ticks[sel];
  assign timeout = step & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      trig <= 1'b0;
    end else begin
      trig <= timeout;
      if (!en || force_ld) cnt <= load;
      else if (step)       cnt <= (cnt == '0) ? load : cnt - W'(1);
    end
  end

  // R7
  ch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == $past(load)));

  // R8
  ch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stall && !force_ld) |=> ($stable(cnt) && !trig));

  // R11
  ch_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_ld |=> (cnt == $past(load) && !trig));
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int MT_W = 8,
  parameter int CH_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  output logic [DW-1:0]             bus_rdata,
  input  logic [NCH-1:0]            timeout,
  input  logic [NCH-1:0][CH_W-1:0]  ch_cnt,
  output ctrl_t                     ctrl,
  output logic [NCH-1:0]            ch_en,
  output logic [NCH-1:0]            sel,
  output logic [NCH-1:0]            ie,
  output logic [NCH-1:0]            flag,
  output logic [NCH-1:0]            ch_force,
  output logic [NMT-1:0]            mt_force,
  output logic [NMT-1:0][MT_W-1:0]  mt_load,
  output logic [NCH-1:0][CH_W-1:0]  ch_load
);
  logic           reld_wr;
  logic [NCH-1:0] flag_clr;

  assign reld_wr  = bus_wr && (bus_addr == A_RELD);
  assign ch_force = reld_wr ? bus_wdata[NCH-1:0] : '0;
  assign mt_force = reld_wr ? bus_wdata[NCH+NMT-1:NCH] : '0;
  assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      ch_en   <= '0;
      sel     <= '0;
      ie      <= '0;
      mt_load <= '0;
      ch_load <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl  <= ctrl_t'(bus_wdata[2:0]);
        A_CHEN:  ch_en <= bus_wdata[NCH-1:0];
        A_SEL:   sel   <= bus_wdata[NCH-1:0];
        A_IE:    ie    <= bus_wdata[NCH-1:0];
        default: ;
      endcase
      for (int k = 0; k < NMT; k++)
        if (bus_addr == A_MTLD0 + AW'(k)) mt_load[k] <= bus_wdata[MT_W-1:0];
      for (int n = 0; n < NCH; n++)
        if (bus_addr == A_CHLD0 + AW'(n)) ch_load[n] <= bus_wdata[CH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~flag_clr) | timeout;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[2:0]     = ctrl;
      A_CHEN:  bus_rdata[NCH-1:0] = ch_en;
      A_SEL:   bus_rdata[NCH-1:0] = sel;
      A_IE:    bus_rdata[NCH-1:0] = ie;
      A_FLAG:  bus_rdata[NCH-1:0] = flag;
      default: ;
    endcase
    for (int k = 0; k < NMT; k++)
      if (bus_addr == A_MTLD0 + AW'(k)) bus_rdata[MT_W-1:0] = mt_load[k];
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == A_CHLD0 + AW'(n)) bus_rdata[CH_W-1:0] = ch_load[n];
      if (bus_addr == A_CHCN0 + AW'(n)) bus_rdata[CH_W-1:0] = ch_cnt[n];
    end
  end

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !(bus_wr && bus_addr == A_FLAG && bus_wdata[0])) |=> flag[0]);
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int MT_W = 8,
  parameter int CH_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           wait_mode,
  input  logic           stop_mode,
  input  logic           freeze_mode,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] trig_o
);
  ctrl_t                     ctrl;
  logic [NCH-1:0]            ch_en, sel, ie, flag, ch_force, timeout;
  logic [NMT-1:0]            mt_force, ticks;
  logic [NMT-1:0][MT_W-1:0]  mt_load;
  logic [NCH-1:0][CH_W-1:0]  ch_load, ch_cnt;
  logic                      stall;

  assign stall = stop_mode
               | (wait_mode   & ctrl.wait_stall)
               | (freeze_mode & ctrl.frz_stall);

  assign irq_o = flag & ie;

  ptimer_regs #(.MT_W(MT_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timeout(timeout),
    .ch_cnt(ch_cnt), .ctrl(ctrl), .ch_en(ch_en), .sel(sel), .ie(ie),
    .flag(flag), .ch_force(ch_force), .mt_force(mt_force),
    .mt_load(mt_load), .ch_load(ch_load)
  );

  for (genvar k = 0; k < NMT; k++) begin : g_pre
    ptimer_prescaler #(.W(MT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(ctrl.glob_en), .stall(stall),
      .force_ld(mt_force[k]), .load(mt_load[k]), .tick(ticks[k])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ptimer_channel #(.W(CH_W), .NTB(NMT)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(ctrl.glob_en & ch_en[n]), .stall(stall),
      .force_ld(ch_force[n]), .ticks(ticks), .sel(sel[n]),
      .load(ch_load[n]), .cnt(ch_cnt[n]), .timeout(timeout[n]),
      .trig(trig_o[n])
    );

    // R4
    trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[n] |-> flag[n]);

    // R6
    irq_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[n] |-> ie[n]);
  end

  // R8
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> (ticks == '0 && timeout == '0));
endmodule

// File: tb/ptimer_top_tb.sv
module ptimer_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // columns: prescaler0 load, prescaler1 load, channel load, select, expected edges
  localparam int VEC [NV][5] = '{
    '{0, 3, 0, 0, 1},
    '{2, 5, 3, 0, 12},
    '{2, 5, 3, 1, 24},
    '{4, 1, 2, 0, 15},
    '{4, 1, 2, 1, 6},
    '{0, 0, 7, 1, 8}
  };

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        wait_mode = 0, stop_mode = 0, freeze_mode = 0;
  logic [3:0]  irq_o, trig_o;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  ptimer_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wait_mode(wait_mode),
    .stop_mode(stop_mode), .freeze_mode(freeze_mode), .irq_o(irq_o),
    .trig_o(trig_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all requirements) actual %0d expected <100000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, int d);
    @(negedge clk);
    bus_addr = a; bus_wdata = 16'(d); bus_wr = 1;
    @(posedge clk);
    #1 bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output int d);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  // counts rising edges until trig_o[0] is seen, sampled on falling edges
  task automatic wait_trig(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!trig_o[0] && n < 2000);
  endtask

  task automatic setup_ch0(int l0, int l1, int c, int s);
    wr(4'd0, 0);
    wr(4'd6, l0); wr(4'd7, l1); wr(4'd8, c); wr(4'd2, s);
    wr(4'd1, 1); wr(4'd3, 0); wr(4'd4, 'hF);
  endtask

  task automatic mode_run(string req, int cbits, bit wm, bit sm, bit fm, bit stalls);
    int a, b, f;
    bit seen;
    setup_ch0(2, 5, 3, 0);
    wr(4'd0, 1 | cbits);
    repeat (5) @(posedge clk);
    @(negedge clk);
    wait_mode = wm; stop_mode = sm; freeze_mode = fm;
    rd(4'd12, a);
    seen = 0;
    repeat (40) begin
      @(posedge clk); @(negedge clk);
      if (trig_o[0]) seen = 1;
    end
    rd(4'd12, b); rd(4'd4, f);
    wait_mode = 0; stop_mode = 0; freeze_mode = 0;
    if (stalls) begin
      chk({req, " count held"}, b, a);
      chk({req, " no flag"}, f, 0);
      chk({req, " no trigger"}, int'(seen), 0);
    end else begin
      chk({req, " runs, flag set"}, f & 1, 1);
    end
  endtask

  initial begin
    int v, n, e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R1 irq after reset", int'(irq_o), 0);
    chk("R1 trig after reset", int'(trig_o), 0);

    // R12 readback
    wr(4'd7, 'hAB); rd(4'd7, v); chk("R12 prescaler1 load readback", v, 'hAB);
    wr(4'd11, 'h1234); rd(4'd11, v); chk("R12 channel3 load readback", v, 'h1234);
    wr(4'd0, 6); rd(4'd0, v); chk("R12 control readback", v, 6);
    rd(4'd5, v); chk("R12 reload strobe reads 0", v, 0);

    // R2 R3 R4 vector walk
    for (int i = 0; i < NV; i++) begin
      setup_ch0(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
      wr(4'd0, 1);
      wait_trig(n);
      chk($sformatf("R3 R2 vector %0d edges to first trigger", i), n, VEC[i][4]);
      rd(4'd4, v); chk($sformatf("R4 vector %0d flag set", i), v & 1, 1);
      if (VEC[i][4] > 1) begin
        @(posedge clk); @(negedge clk);
        chk($sformatf("R4 vector %0d trigger one cycle", i), int'(trig_o[0]), 0);
      end
    end

    // R6 R5 interrupt and flag clearing
    setup_ch0(2, 5, 3, 0);
    wr(4'd0, 1);
    wait_trig(n);
    chk("R6 irq low with enable clear", int'(irq_o[0]), 0);
    wr(4'd0, 0);
    wr(4'd3, 1);
    chk("R6 irq high with flag and enable", int'(irq_o[0]), 1);
    wr(4'd4, 0); rd(4'd4, v);
    chk("R5 write 0 keeps flag", v & 1, 1);
    wr(4'd4, 1); rd(4'd4, v);
    chk("R5 write 1 clears flag", v & 1, 0);
    chk("R6 irq drops with flag", int'(irq_o[0]), 0);

    // R7 disabled channel holds load
    setup_ch0(0, 0, 3, 0);
    wr(4'd1, 0);
    wr(4'd0, 1);
    repeat (30) @(posedge clk);
    @(negedge clk);
    rd(4'd12, v); chk("R7 channel disabled count held at load", v, 3);
    rd(4'd4, v);  chk("R7 channel disabled no flag", v, 0);
    wr(4'd1, 1); wr(4'd0, 0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    rd(4'd12, v); chk("R7 module disabled count held at load", v, 3);
    rd(4'd4, v);  chk("R7 module disabled no flag", v, 0);

    // R8 R9 R10 low-power modes
    mode_run("R8 stop, bits clear", 0, 0, 1, 0, 1);
    mode_run("R8 stop, bits set", 6, 0, 1, 0, 1);
    mode_run("R9 wait, bit clear", 0, 1, 0, 0, 0);
    mode_run("R9 wait, bit set", 2, 1, 0, 0, 1);
    mode_run("R10 freeze, bit clear", 0, 0, 0, 1, 0);
    mode_run("R10 freeze, bit set", 4, 0, 0, 1, 1);

    // R11 forced reload
    setup_ch0(2, 5, 3, 0);
    wr(4'd0, 1);
    repeat (5) @(posedge clk);
    wr(4'd5, 'h11);
    rd(4'd12, v); chk("R11 channel reloaded", v, 3);
    rd(4'd4, v);  chk("R11 reload makes no flag", v, 0);
    wait_trig(n);
    e = (2 + 1) * (3 + 1);
    chk("R11 full period after reload", n, e);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule